// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a three-level translation table that sits in memory. A caller hands it a virtual address and a context number. The walker first reads the root pointer of that context from a context table at a fixed base address. It then reads one entry from each of the three table levels, and each read uses a field of the virtual address as its index. Reads go out one at a time over a plain request/response memory port. The walker waits for each response before it forms the next address.

The virtual address splits into three index fields and a page offset. Bits 31:24 index the first-level table, which holds 256 entries. Bits 23:18 index the second-level table (64 entries). Bits 17:12 index the third-level table (64 entries). Bits 11:0 are the offset. Second- and third-level tables exist only where they are needed, so any entry along the path may be marked not valid. When that happens the walk stops and reports a fault together with the level at which it stopped. A successful walk returns the physical address and the permission and status bits of the leaf entry.

Top module: `pt_walker`

## Requirements
- R1: A request is taken only at a clock edge where `req_valid` is high and `busy` is low. `busy` goes high in the next cycle and stays high up to and including the `done` cycle. Requests presented while `busy` is high are ignored.
- R2: The first read of a walk goes to the context-table entry at `CTX_BASE + ctx*4`.
- R3: A valid context entry gives the first-level table base as its bits 31:10 with the low 10 bits cleared. The second read goes to that base plus `vaddr[31:24]*4`.
- R4: A valid first-level entry gives the second-level base as its bits 31:8 with the low 8 bits cleared, and the third read goes to that base plus `vaddr[23:18]*4`. A valid second-level entry gives the third-level base the same way, and the fourth read goes to that base plus `vaddr[17:12]*4`.
- R5: `mem_rd_en` is high for exactly one cycle per read, and `mem_addr` holds its value until the response arrives. The next read is issued only in the cycle after a response. A response that arrives while no read is outstanding is ignored.
- R6: Bit 0 of every entry is its valid bit. An entry with bit 0 clear ends the walk without any further read. The walker then reports `fault`=1, `fault_level` = the level of the entry (0 for context, 1, 2, 3 for the table levels), and `paddr`=0, `perm`=0.
- R7: A valid third-level entry ends the walk with `fault`=0 and `fault_level`=0. `paddr` is the entry's bits 31:12 joined to `vaddr[11:0]`. `perm` is the entry's bits 5:0, laid out as valid[0], read[1], write[2], execute[3], referenced[4], modified[5].
- R8: `done` is a one-cycle pulse in the cycle after the final response edge. `busy` is low in the cycle after `done`. The result outputs stay unchanged until the next `done`.
- R9: While reset is held, `busy`, `mem_rd_en`, `done`, `fault`, `fault_level`, `paddr` and `perm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 12 | Context number |
| busy | output | 1 | Walk in progress |
| mem_rd_en | output | 1 | Memory read request, one cycle |
| mem_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_data | input | 32 | Memory read data (table entry) |
| done | output | 1 | Walk finished, one cycle |
| fault | output | 1 | Walk ended on an invalid entry |
| fault_level | output | 2 | Level of the invalid entry |
| paddr | output | 32 | Translated physical address |
| perm | output | 6 | Leaf permission and status bits |

## Verification
The first read request appears one cycle after the accepting edge. Each later request appears one cycle after the edge that carries the previous response. `done` and the results appear one cycle after the final response edge, so a walk with response latency L per read takes 1 + 4(L+1) cycles to reach `done`. The bench keeps a behavioural model that advances on the same rising edges as the design. The model decides from the inputs of that edge alone what each output must be in the following cycle. Every output is then compared on the falling edge, away from the edge where it changes. Latencies of 1 to 4 cycles, requests held during a walk, and stray responses are used so that any output that is early or late by one cycle shows up as a mismatch.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int          CTX_W    = 12,
  parameter int          L1_W     = 8,
  parameter int          L2_W     = 6,
  parameter int          L3_W     = 6,
  parameter int          OFF_W    = 12,
  parameter int          PERM_W   = 6,
  parameter logic [31:0] CTX_BASE = 32'h0004_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [L1_W+L2_W+L3_W+OFF_W-1:0] req_vaddr,
  input  logic [CTX_W-1:0]              req_ctx,
  output logic                          busy,
  output logic                          mem_rd_en,
  output logic [L1_W+L2_W+L3_W+OFF_W-1:0] mem_addr,
  input  logic                          mem_rsp_valid,
  input  logic [L1_W+L2_W+L3_W+OFF_W-1:0] mem_rsp_data,
  output logic                          done,
  output logic                          fault,
  output logic [1:0]                    fault_level,
  output logic [L1_W+L2_W+L3_W+OFF_W-1:0] paddr,
  output logic [PERM_W-1:0]             perm
);
  localparam int AW = L1_W + L2_W + L3_W + OFF_W;
  localparam logic [AW-1:0] BASE1_MASK = ~((AW'(1) << (L1_W + 2)) - AW'(1));
  localparam logic [AW-1:0] BASE2_MASK = ~((AW'(1) << (L2_W + 2)) - AW'(1));
  localparam logic [AW-1:0] BASE3_MASK = ~((AW'(1) << (L3_W + 2)) - AW'(1));

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t           st;
  logic [1:0]       lvl;
  logic [AW-1:0]    va_q;
  logic [AW-1:0]    base_q;
  logic [CTX_W-1:0] ctx_q;

  wire [L1_W-1:0] idx1 = va_q[AW-1 -: L1_W];
  wire [L2_W-1:0] idx2 = va_q[OFF_W+L3_W +: L2_W];
  wire [L3_W-1:0] idx3 = va_q[OFF_W +: L3_W];
  wire            entry_ok = mem_rsp_data[0];

  assign busy      = (st != S_IDLE);
  assign mem_rd_en = (st == S_ISSUE);
  assign done      = (st == S_DONE);

  always_comb begin
    case (lvl)
      2'd0:    mem_addr = CTX_BASE[AW-1:0] + (AW'(ctx_q) << 2);
      2'd1:    mem_addr = base_q + (AW'(idx1) << 2);
      2'd2:    mem_addr = base_q + (AW'(idx2) << 2);
      default: mem_addr = base_q + (AW'(idx3) << 2);
    endcase
  end

  logic [AW-1:0] next_base;
  always_comb begin
    case (lvl)
      2'd0:    next_base = mem_rsp_data & BASE1_MASK;
      2'd1:    next_base = mem_rsp_data & BASE2_MASK;
      default: next_base = mem_rsp_data & BASE3_MASK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      lvl         <= 2'd0;
      va_q        <= '0;
      base_q      <= '0;
      ctx_q       <= '0;
      fault       <= 1'b0;
      fault_level <= 2'd0;
      paddr       <= '0;
      perm        <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          ctx_q <= req_ctx;
          lvl   <= 2'd0;
          st    <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!entry_ok) begin
            fault       <= 1'b1;
            fault_level <= lvl;
            paddr       <= '0;
            perm        <= '0;
            st          <= S_DONE;
          end else if (lvl == 2'd3) begin
            fault       <= 1'b0;
            fault_level <= 2'd0;
            paddr       <= {mem_rsp_data[AW-1:OFF_W], va_q[OFF_W-1:0]};
            perm        <= mem_rsp_data[PERM_W-1:0];
            st          <= S_DONE;
          end else begin
            base_q <= next_base;
            lvl    <= lvl + 2'd1;
            st     <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW     = 32,
  parameter int PERM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              mem_rd_en,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault,
  input logic [1:0]        fault_level,
  input logic [AW-1:0]     paddr,
  input logic [PERM_W-1:0] perm
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R5
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> $stable(mem_addr));

  // R5
  rd_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy && !done);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(paddr) && $stable(perm) && $stable(fault) && $stable(fault_level));

  // R6
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> perm == '0 && paddr == '0);

  // R7
  leaf_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> perm[0] && fault_level == 2'd0);

  // R5
  no_rd_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !$past(mem_rd_en));

  wire unused_rsp = mem_rsp_valid;
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .PERM_W(PERM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
  .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr), .perm(perm)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam logic [31:0] CB = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [11:0] req_ctx = '0;
  logic        busy, mem_rd_en, done, fault;
  logic [31:0] mem_addr, paddr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [1:0]  fault_level;
  logic [5:0]  perm;

  always #10 clk = ~clk;

  pt_walker #(.CTX_BASE(CB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ctx(req_ctx), .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .fault(fault), .fault_level(fault_level), .paddr(paddr), .perm(perm)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder
  int          lat = 1;
  bit          spur = 0;
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    if (pend) begin
      cnt--;
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
        pend = 0;
      end
    end else if (mem_rd_en && rst_n) begin
      pend = 1; cnt = lat; pend_addr = mem_addr;
    end else if (spur && rst_n) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'h0;
    end
  end

  // behavioural reference: 0 idle, 1 issue, 2 wait, 3 done
  int          mst = 0;
  int          mlvl = 0;
  logic [31:0] mva = '0, mbase = '0, mpaddr = '0;
  logic [11:0] mctx = '0;
  logic [5:0]  mperm = '0;
  logic        mfault = 0;
  logic [1:0]  mflvl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mlvl = 0; mpaddr = 0; mperm = 0; mfault = 0; mflvl = 0;
    end else begin
      case (mst)
        0: if (req_valid) begin mva = req_vaddr; mctx = req_ctx; mlvl = 0; mst = 1; end
        1: mst = 2;
        2: if (mem_rsp_valid) begin
          if (mem_rsp_data[0] == 1'b0) begin
            mfault = 1; mflvl = 2'(mlvl); mpaddr = 0; mperm = 0; mst = 3;
          end else if (mlvl == 3) begin
            mfault = 0; mflvl = 0;
            mpaddr = {mem_rsp_data[31:12], mva[11:0]};
            mperm = mem_rsp_data[5:0]; mst = 3;
          end else begin
            if (mlvl == 0) mbase = {mem_rsp_data[31:10], 10'h0};
            else mbase = {mem_rsp_data[31:8], 8'h0};
            mlvl++; mst = 1;
          end
        end
        default: mst = 0;
      endcase
    end
  end

  function automatic logic [31:0] exp_addr();
    case (mlvl)
      0: return CB + {18'h0, mctx, 2'b00};
      1: return mbase + {22'h0, mva[31:24], 2'b00};
      2: return mbase + {24'h0, mva[23:18], 2'b00};
      default: return mbase + {24'h0, mva[17:12], 2'b00};
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "busy", {31'h0, busy}, {31'h0, mst != 0});
      chk("R5", "mem_rd_en", {31'h0, mem_rd_en}, {31'h0, mst == 1});
      if (mst == 1 || mst == 2) begin
        if (mlvl == 0)      chk("R2", "mem_addr", mem_addr, exp_addr());
        else if (mlvl == 1) chk("R3", "mem_addr", mem_addr, exp_addr());
        else                chk("R4", "mem_addr", mem_addr, exp_addr());
      end
      chk("R8", "done", {31'h0, done}, {31'h0, mst == 3});
      chk("R6", "fault", {31'h0, fault}, {31'h0, mfault});
      chk("R6", "fault_level", {30'h0, fault_level}, {30'h0, mflvl});
      chk("R7", "paddr", paddr, mpaddr);
      chk("R7", "perm", {26'h0, perm}, {26'h0, mperm});
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      compared++; mismatched++;
      $display("FAIL R8 watchdog done actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic walk(logic [31:0] va, logic [11:0] ctx, int l, bit noise);
    lat = l;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_ctx = ctx;
    @(negedge clk);
    if (noise) begin req_vaddr = ~va; req_ctx = ~ctx; end
    else req_valid = 1'b0;
    while (!done) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    mem[32'h0004_0014] = 32'h0010_0001;
    mem[32'h0010_0048] = 32'h0020_0101;
    mem[32'h0020_0114] = 32'h0030_0201;
    mem[32'h0030_02FC] = 32'hABCD_E017;
    mem[32'h0004_3FFC] = 32'h0050_03FD;
    mem[32'h0050_03FC] = 32'h0060_01FF;
    mem[32'h0060_01FC] = 32'h0070_0001;
    mem[32'h0070_0000] = 32'h1234_5023;

    repeat (2) @(negedge clk);
    // R9 reset values
    chk("R9", "busy", {31'h0, busy}, 32'h0);
    chk("R9", "mem_rd_en", {31'h0, mem_rd_en}, 32'h0);
    chk("R9", "done", {31'h0, done}, 32'h0);
    chk("R9", "fault", {31'h0, fault}, 32'h0);
    chk("R9", "fault_level", {30'h0, fault_level}, 32'h0);
    chk("R9", "paddr", paddr, 32'h0);
    chk("R9", "perm", {26'h0, perm}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    walk({8'h12, 6'h05, 6'h3F, 12'h9A4}, 12'd5, 1, 0);
    chk("R7", "leaf paddr", paddr, 32'hABCD_E9A4);
    chk("R7", "leaf perm", {26'h0, perm}, 32'h17);

    walk({8'hFF, 6'h3F, 6'h00, 12'hFFF}, 12'hFFF, 3, 1);
    chk("R3", "masked walk paddr", paddr, 32'h1234_5FFF);
    chk("R7", "masked walk perm", {26'h0, perm}, 32'h23);

    walk(32'h1234_5678, 12'd7, 2, 0);
    chk("R6", "ctx fault level", {30'h0, fault_level}, 32'h0);
    chk("R6", "ctx fault", {31'h0, fault}, 32'h1);

    spur = 1;
    walk({8'h13, 6'h05, 6'h3F, 12'h000}, 12'd5, 4, 1);
    chk("R6", "l1 fault level", {30'h0, fault_level}, 32'h1);
    spur = 0;

    walk({8'h12, 6'h06, 6'h3F, 12'h000}, 12'd5, 1, 0);
    chk("R6", "l2 fault level", {30'h0, fault_level}, 32'h2);

    walk({8'h12, 6'h05, 6'h00, 12'h123}, 12'd5, 2, 1);
    chk("R6", "l3 fault level", {30'h0, fault_level}, 32'h3);
    chk("R6", "l3 fault paddr", paddr, 32'h0);

    spur = 1;
    repeat (5) @(negedge clk);
    chk("R5", "stray response idle busy", {31'h0, busy}, 32'h0);
    spur = 0;
    walk({8'h12, 6'h05, 6'h3F, 12'h001}, 12'd5, 2, 0);
    chk("R7", "repeat paddr", paddr, 32'hABCD_E001);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule